// File: doc/BRIEF.md
# Five-Level Priority Interrupt Controller

This block decides which of five interrupt sources a small 8-bit processor core should service next. The sources are one non-maskable input, three restart inputs with fixed vectors (named after their levels 7.5, 6.5 and 5.5), and one general-purpose request. The core pulses an instruction-boundary strobe when it is ready to take an interrupt. The block applies a fixed priority order, a global enable flag and per-restart masks. In the cycle after the boundary it reports at most one accepted source, together with its vector address.

The core controls the global enable with set and clear pulses. It loads the three restart masks with a write strobe and can discard a latched 7.5 edge with a clear pulse. A granted general-purpose request returns no fixed vector. The block instead raises an acknowledge pulse, and the requesting device answers it by supplying the opcode.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_valid_o` and `inta_o` are low, the global enable is clear and all three restart masks are set, so no maskable source is granted until the core enables it.
- R2: A pending non-maskable request is granted ahead of every other source, whatever the global enable and the masks hold. It reports `irq_src_o` = 1 and vector 0x0024.
- R3: The non-maskable input becomes pending on a rising edge and stays pending only while its level stays high. One long pulse is granted once, and a pulse that falls before a boundary is never granted.
- R4: Among the maskable sources the order is 7.5, then 6.5, then 5.5, then the general-purpose request.
- R5: Source codes and vectors are: 7.5 gives code 2 and vector 0x003C, 6.5 gives code 3 and vector 0x0034, 5.5 gives code 4 and vector 0x002C.
- R6: A rising edge on `rst75_i` is held in a latch, through any mask, until the latch is granted or `clr75_i` drops it. An edge in the same cycle as the clear still sets the latch.
- R7: The 6.5 and 5.5 inputs are level sensitive. A request that is gone by the boundary is not granted.
- R8: A maskable source is granted only while the global enable is set. `ie_set_i` sets the enable and `ie_clr_i` clears it, and the clear wins when both are high. Any grant clears the enable. A grant decision uses the enable value from before that edge.
- R9: A pulse on `mask_wr_i` loads `mask_i`: bit 2 masks 7.5, bit 1 masks 6.5 and bit 0 masks 5.5, and 1 means blocked. The masks have no effect on the general-purpose request.
- R10: A granted general-purpose request reports code 5 and vector 0x0000, and raises `inta_o` for that one cycle. `inta_o` stays low for every other source.
- R11: Requests are evaluated only at a clock edge where `boundary_i` is high. The result appears one cycle after that edge as a one-cycle pulse on `irq_valid_o`, with at most one source per boundary. When nothing is granted, the code and vector are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_i | input | 1 | Non-maskable request |
| rst75_i | input | 1 | Edge-triggered restart request, level 7.5 |
| rst65_i | input | 1 | Level restart request, level 6.5 |
| rst55_i | input | 1 | Level restart request, level 5.5 |
| gen_i | input | 1 | General-purpose request |
| boundary_i | input | 1 | Instruction-boundary strobe from the core |
| ie_set_i | input | 1 | Set the global enable |
| ie_clr_i | input | 1 | Clear the global enable |
| mask_wr_i | input | 1 | Load restart masks |
| mask_i | input | 3 | New mask values (bit 2 = 7.5, bit 1 = 6.5, bit 0 = 5.5) |
| clr75_i | input | 1 | Discard a latched 7.5 edge |
| irq_valid_o | output | 1 | One-cycle pulse: a source was accepted |
| irq_src_o | output | 3 | Accepted source code (0 none, 1..5) |
| irq_vec_o | output | 16 | Vector address of the accepted source |
| inta_o | output | 1 | Acknowledge pulse for the general-purpose request |

## Verification
The assertions assume that every input is synchronous to `clk` and already free of metastability. They also assume that reset is held low for at least one edge before any property matters. Their checks on edges and pending state rely on the inputs holding one value for a whole cycle. The stimulus meets these assumptions by changing every input only at the falling clock edge. It mixes random request, strobe and control activity with directed sequences that cover long non-maskable pulses, masked 7.5 edges and simultaneous set and clear of the enable.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NUM_SRC = 5;
    localparam int NUM_RST = 3;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_NMI  = 3'd1,
        SRC_R75  = 3'd2,
        SRC_R65  = 3'd3,
        SRC_R55  = 3'd4,
        SRC_GEN  = 3'd5
    } src_e;
endpackage

// File: rtl/pic_edge_hold.sv
// Rising-edge capture with optional level qualification.
module pic_edge_hold #(
    parameter bit LEVEL_QUAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic take_i,
    input  logic clr_i,
    output logic pend_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } hold_t;

    hold_t s_d, s_q;
    logic  qual;

    generate
        if (LEVEL_QUAL) begin : g_level
            assign qual = req_i;
        end else begin : g_edge
            assign qual = 1'b1;
        end
    endgenerate

    always_comb begin
        s_d      = s_q;
        s_d.prev = req_i;
        s_d.pend = ((req_i & ~s_q.prev) | (s_q.pend & ~take_i & ~clr_i)) & qual;
    end

    assign pend_o = s_q.pend & qual;

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_PEND_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pend && !$past(s_q.pend)) |-> ($past(req_i) && !$past(s_q.prev))) else $error("pend without edge"); // R6
    AST_GRANT_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> pend_o) else $error("take without pend"); // R3
endmodule

// File: rtl/pic_arbiter.sv
// Fixed-priority selection; index 0 is highest (non-maskable).
module pic_arbiter
    import pic_pkg::*;
(
    input  logic               eval_i,
    input  logic               ie_i,
    input  logic [NUM_RST-1:0] mask_i,
    input  logic               nmi_ok_i,
    input  logic               l75_i,
    input  logic               r65_i,
    input  logic               r55_i,
    input  logic               gen_i,
    output logic [NUM_SRC-1:0] grant_o
);
    logic [NUM_SRC-1:0] cand;
    logic               taken;

    always_comb begin
        cand[0] = nmi_ok_i;
        cand[1] = l75_i & ~mask_i[2] & ie_i;
        cand[2] = r65_i & ~mask_i[1] & ie_i;
        cand[3] = r55_i & ~mask_i[0] & ie_i;
        cand[4] = gen_i & ie_i;
        grant_o = '0;
        taken   = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (eval_i && cand[i] && !taken) begin
                grant_o[i] = 1'b1;
                taken      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int               VEC_W   = 16,
    parameter logic [VEC_W-1:0] VEC_NMI = 16'h0024,
    parameter logic [VEC_W-1:0] VEC_R75 = 16'h003C,
    parameter logic [VEC_W-1:0] VEC_R65 = 16'h0034,
    parameter logic [VEC_W-1:0] VEC_R55 = 16'h002C,
    parameter logic [VEC_W-1:0] VEC_GEN = 16'h0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nmi_i,
    input  logic               rst75_i,
    input  logic               rst65_i,
    input  logic               rst55_i,
    input  logic               gen_i,
    input  logic               boundary_i,
    input  logic               ie_set_i,
    input  logic               ie_clr_i,
    input  logic               mask_wr_i,
    input  logic [2:0]         mask_i,
    input  logic               clr75_i,
    output logic               irq_valid_o,
    output logic [2:0]         irq_src_o,
    output logic [VEC_W-1:0]   irq_vec_o,
    output logic               inta_o
);
    localparam logic [VEC_W-1:0] VEC_TAB [NUM_SRC] = '{VEC_NMI, VEC_R75, VEC_R65, VEC_R55, VEC_GEN};

    typedef struct packed {
        logic               ie;
        logic [NUM_RST-1:0] mask;
        logic               valid;
        src_e               src;
        logic [VEC_W-1:0]   vec;
        logic               inta;
    } ctrl_t;

    ctrl_t              c_d, c_q;
    logic [NUM_SRC-1:0] grant;
    logic               nmi_ok;
    logic               l75;

    pic_edge_hold #(.LEVEL_QUAL(1'b1)) u_nmi_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (nmi_i),
        .take_i (grant[0]),
        .clr_i  (1'b0),
        .pend_o (nmi_ok)
    );

    pic_edge_hold #(.LEVEL_QUAL(1'b0)) u_r75_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (rst75_i),
        .take_i (grant[1]),
        .clr_i  (clr75_i),
        .pend_o (l75)
    );

    pic_arbiter u_arb (
        .eval_i   (boundary_i),
        .ie_i     (c_q.ie),
        .mask_i   (c_q.mask),
        .nmi_ok_i (nmi_ok),
        .l75_i    (l75),
        .r65_i    (rst65_i),
        .r55_i    (rst55_i),
        .gen_i    (gen_i),
        .grant_o  (grant)
    );

    always_comb begin
        c_d       = c_q;
        c_d.valid = |grant;
        c_d.inta  = grant[4];
        c_d.src   = SRC_NONE;
        c_d.vec   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i]) begin
                c_d.src = src_e'(3'(i + 1));
                c_d.vec = VEC_TAB[i];
            end
        end
        if (ie_set_i)  c_d.ie = 1'b1;
        if (ie_clr_i)  c_d.ie = 1'b0;
        if (|grant)    c_d.ie = 1'b0;
        if (mask_wr_i) c_d.mask = mask_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q      <= '0;
            c_q.mask <= '1;
            c_q.src  <= SRC_NONE;
        end else begin
            c_q <= c_d;
        end
    end

    assign irq_valid_o = c_q.valid;
    assign irq_src_o   = c_q.src;
    assign irq_vec_o   = c_q.vec;
    assign inta_o      = c_q.inta;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)) else $error("multiple grants"); // R11
    AST_GRANT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> boundary_i) else $error("grant off boundary"); // R11
    AST_VALID_AFTER_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> $past(boundary_i)) else $error("valid without boundary"); // R11
    AST_IE_OFF_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> !c_q.ie) else $error("enable survived grant"); // R8
    AST_MASKABLE_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && irq_src_o != SRC_NMI) |-> $past(c_q.ie)) else $error("grant with enable clear"); // R8
    AST_INTA_GEN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        inta_o |-> (irq_valid_o && irq_src_o == SRC_GEN)) else $error("stray acknowledge"); // R10
    AST_R65_MASK_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && irq_src_o == SRC_R65) |-> !$past(c_q.mask[1])) else $error("masked 6.5 granted"); // R9
    AST_NMI_NOT_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && irq_src_o == SRC_NMI) |=> !(irq_valid_o && irq_src_o == SRC_NMI)) else $error("nmi twice"); // R3
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        nmi, r75, r65, r55, gen, bnd, ies, iec, mwr, c75;
    logic [2:0]  msk;
    logic        v_o, inta_o;
    logic [2:0]  src_o;
    logic [15:0] vec_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference state
    logic       m_ie, m_l75, m_np, m_p75, m_pn;
    logic [2:0] m_mask;
    logic       e_valid, e_inta;
    logic [2:0] e_src;
    logic [15:0] e_vec;

    always #5 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .rst75_i(r75), .rst65_i(r65),
        .rst55_i(r55), .gen_i(gen), .boundary_i(bnd), .ie_set_i(ies),
        .ie_clr_i(iec), .mask_wr_i(mwr), .mask_i(msk), .clr75_i(c75),
        .irq_valid_o(v_o), .irq_src_o(src_o), .irq_vec_o(vec_o), .inta_o(inta_o)
    );

    function automatic logic [15:0] vec_of(input logic [2:0] code);
        case (code)
            3'd1: return 16'h0024;
            3'd2: return 16'h003C;
            3'd3: return 16'h0034;
            3'd4: return 16'h002C;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [2:0] pick(input logic nmi_ok, l75ok, r65ok, r55ok, genok);
        if (nmi_ok) return 3'd1;
        if (l75ok)  return 3'd2;
        if (r65ok)  return 3'd3;
        if (r55ok)  return 3'd4;
        if (genok)  return 3'd5;
        return 3'd0;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic i_nmi, i_r75, i_r65, i_r55, i_gen, i_bnd,
                        i_ies, i_iec, i_mwr, input logic [2:0] i_msk,
                        input logic i_c75, input string tag);
        logic [2:0] g;
        nmi = i_nmi; r75 = i_r75; r65 = i_r65; r55 = i_r55; gen = i_gen;
        bnd = i_bnd; ies = i_ies; iec = i_iec; mwr = i_mwr; msk = i_msk; c75 = i_c75;
        g = i_bnd ? pick(m_np & i_nmi, m_l75 & ~m_mask[2] & m_ie,
                         i_r65 & ~m_mask[1] & m_ie, i_r55 & ~m_mask[0] & m_ie,
                         i_gen & m_ie) : 3'd0;
        e_valid = (g != 3'd0);
        e_src   = g;
        e_vec   = vec_of(g);
        e_inta  = (g == 3'd5);
        m_np  = i_nmi & ((i_nmi & ~m_pn) | (m_np & ~(g == 3'd1)));
        m_l75 = (i_r75 & ~m_p75) | (m_l75 & ~(g == 3'd2) & ~i_c75);
        m_pn  = i_nmi;
        m_p75 = i_r75;
        if (i_ies) m_ie = 1'b1;
        if (i_iec) m_ie = 1'b0;
        if (g != 3'd0) m_ie = 1'b0;
        if (i_mwr) m_mask = i_msk;
        @(negedge clk);
        chk(tag, "valid", 32'(v_o), 32'(e_valid));
        chk(tag, "src",   32'(src_o), 32'(e_src));
        chk(tag, "vec",   32'(vec_o), 32'(e_vec));
        chk(tag, "inta",  32'(inta_o), 32'(e_inta));
    endtask

    task automatic idle(input string tag);
        step(0,0,0,0,0,0,0,0,0,3'd0,0,tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        {nmi, r75, r65, r55, gen, bnd, ies, iec, mwr, c75} = '0;
        msk = 3'd0;
        m_ie = 0; m_l75 = 0; m_np = 0; m_p75 = 0; m_pn = 0; m_mask = 3'b111;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "valid after reset", 32'(v_o), 32'd0);
        chk("R1", "inta after reset", 32'(inta_o), 32'd0);

        // R1: enable clear and masks set after reset
        step(0,0,0,0,1,1,0,0,0,3'd0,0,"R1");
        chk("R1", "gen blocked", 32'(v_o), 32'd0);
        step(0,0,1,0,0,1,0,0,0,3'd0,0,"R1");
        // R8/R9: enable and unmask
        step(0,0,0,0,0,0,1,0,1,3'd0,0,"R8");
        // R4: order among maskable
        step(0,0,1,1,1,1,0,0,0,3'd0,0,"R4");
        chk("R4", "6.5 wins", 32'(src_o), 32'd3);
        step(0,0,0,0,0,0,1,0,0,3'd0,0,"R8");
        step(0,0,0,1,1,1,0,0,0,3'd0,0,"R4");
        chk("R5", "5.5 vector", 32'(vec_o), 32'h002C);
        // R8: accept cleared enable
        step(0,0,0,0,1,1,0,0,0,3'd0,0,"R8");
        chk("R8", "enable cleared by grant", 32'(v_o), 32'd0);
        // R10: general request
        step(0,0,0,0,0,0,1,0,0,3'd0,0,"R10");
        step(0,0,0,0,1,1,0,0,0,3'd0,0,"R10");
        chk("R10", "inta", 32'(inta_o), 32'd1);
        idle("R10");
        chk("R10", "inta one cycle", 32'(inta_o), 32'd0);
        // R2: nmi with enable clear and all masked
        step(0,0,0,0,0,0,0,0,1,3'd7,0,"R2");
        step(1,0,0,0,0,0,0,0,0,3'd0,0,"R2");
        step(1,0,0,0,1,1,0,0,0,3'd0,0,"R2");
        chk("R2", "nmi src", 32'(src_o), 32'd1);
        chk("R2", "nmi vec", 32'(vec_o), 32'h0024);
        // R3: long pulse only once; short pulse dropped
        step(1,0,0,0,0,0,1,0,0,3'd0,0,"R3");
        step(1,0,0,0,0,1,0,0,0,3'd0,0,"R3");
        chk("R3", "long pulse once", 32'(v_o), 32'd0);
        idle("R3");
        step(1,0,0,0,0,0,0,0,0,3'd0,0,"R3");
        step(0,0,0,0,0,1,0,0,0,3'd0,0,"R3");
        chk("R3", "dropped pulse", 32'(v_o), 32'd0);
        // R6: masked edge held, then granted
        step(0,0,0,0,0,0,1,0,1,3'b100,0,"R6");
        step(0,1,0,0,0,0,0,0,0,3'd0,0,"R6");
        step(0,0,0,0,0,0,0,0,0,3'd0,0,"R6");
        step(0,0,0,0,0,1,0,0,0,3'd0,0,"R6");
        chk("R6", "masked latch", 32'(v_o), 32'd0);
        step(0,0,0,0,0,0,0,0,1,3'b000,0,"R6");
        step(0,0,0,0,0,1,0,0,0,3'd0,0,"R6");
        chk("R6", "latched 7.5", 32'(src_o), 32'd2);
        chk("R5", "7.5 vector", 32'(vec_o), 32'h003C);
        // R6: clear discards latch
        step(0,0,0,0,0,0,1,0,0,3'd0,0,"R6");
        step(0,1,0,0,0,0,0,0,0,3'd0,0,"R6");
        step(0,0,0,0,0,0,0,0,0,3'd0,1,"R6");
        step(0,0,0,0,0,1,0,0,0,3'd0,0,"R6");
        chk("R6", "cleared latch", 32'(v_o), 32'd0);
        // R6: edge and clear together keeps the latch
        step(0,0,0,0,0,0,0,0,0,3'd0,0,"R6");
        step(0,1,0,0,0,0,0,0,0,3'd0,1,"R6");
        step(0,0,0,0,0,1,0,0,0,3'd0,0,"R6");
        chk("R6", "edge beats clear", 32'(src_o), 32'd2);
        // R7: level sources have no memory
        step(0,0,0,0,0,0,1,0,0,3'd0,0,"R7");
        step(0,0,1,1,0,0,0,0,0,3'd0,0,"R7");
        step(0,0,0,0,0,1,0,0,0,3'd0,0,"R7");
        chk("R7", "level gone", 32'(v_o), 32'd0);
        // R9: mask blocks 6.5 but not general request
        step(0,0,0,0,0,0,0,0,1,3'b010,0,"R9");
        step(0,0,1,0,0,1,0,0,0,3'd0,0,"R9");
        chk("R9", "6.5 masked", 32'(v_o), 32'd0);
        step(0,0,1,0,1,1,0,0,1,3'b111,0,"R9");
        chk("R9", "gen ignores masks", 32'(src_o), 32'd5);
        // R8: clear wins over set
        step(0,0,0,0,0,0,1,1,0,3'd0,0,"R8");
        step(0,0,0,0,1,1,0,0,0,3'd0,0,"R8");
        chk("R8", "clear beats set", 32'(v_o), 32'd0);
        // R11: no evaluation without boundary
        step(0,0,0,0,0,0,1,0,0,3'd0,0,"R11");
        step(0,0,0,0,1,0,0,0,0,3'd0,0,"R11");
        chk("R11", "no boundary", 32'(v_o), 32'd0);
        step(0,0,0,0,1,1,0,0,0,3'd0,0,"R11");
        chk("R11", "boundary grant", 32'(v_o), 32'd1);
        idle("R11");
        chk("R11", "single pulse", 32'(v_o), 32'd0);

        // random phase
        for (int k = 0; k < 4000; k++) begin
            step(($urandom % 12) == 0, ($urandom % 4) == 0, ($urandom % 2) == 0,
                 ($urandom % 2) == 0, ($urandom % 2) == 0, ($urandom % 3) == 0,
                 ($urandom % 3) == 0, ($urandom % 16) == 0, ($urandom % 8) == 0,
                 3'($urandom), ($urandom % 16) == 0, "R11");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule